// File: doc/BRIEF.md
# Serial Flash Write-Enable and Status Control

This block holds the write-permission and status state of a serial flash command engine. The engine reports decoded events to it: a full opcode has been shifted in (with its command class), the active command finished, the active command aborted, a hold condition aborted the operation, and a power-up or software reset. For erase and program commands the engine also reports whether any byte failed. The write-protect pin level and a per-sector protect vector come in directly.

The block keeps the write enable latch and the erase/program error flag. It tracks whether a granted modifying command is in progress. It derives a three-state protection summary from the sector vector and mirrors the write-protect pin. For each modifying opcode it answers with a one-cycle grant or refuse pulse. A registered status byte gathers the whole state for the read-status path.

Top module: `flash_wel_status`

## Requirements
- R1: After the asynchronous reset, and in the cycle after a `por_i` strobe, the latch (status bit 1), the error flag (bit 5) and busy (bit 0) are 0.
- R2: Command classes are coded 1 program, 2 block erase, 3 chip erase, 4 protect sector, 5 unprotect sector, 6 lockdown, 7 freeze lockdown, 8 OTP program and 9 write status; 1 to 9 are modifying and every other code is non-modifying. A modifying opcode with the latch at 0 gives `refuse_o` for one cycle and does not set busy. With the latch at 1 it gives `grant_o` for one cycle and sets busy until the command ends.
- R3: A write-enable strobe sets the latch and a write-disable strobe clears it. When a set and any clear event come in the same cycle, the latch ends up 0.
- R4: A granted modifying command clears the latch and busy when it completes and also when it aborts.
- R5: A hold abort clears the latch, and busy if it is set.
- R6: An abort with no full opcode received, or an abort after a non-modifying or unrecognized opcode, leaves the latch unchanged.
- R7: When a granted erase or program command (classes 1, 2, 3, 8) completes, the error flag takes the value of `fail_i`. Completion of any other class leaves the flag unchanged.
- R8: An aborted or refused erase or program operation leaves the error flag unchanged.
- R9: Status bits 3:2 read 00 when no sector is protected, 01 when some are and 11 when all are. The value 10 never appears.
- R10: Status bit 4 follows the level of `wp_i`.
- R11: Status bits 7:6 are 0. Every status field reflects the events and inputs present one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-up / software reset event strobe |
| wren_i | input | 1 | Write-enable command completed |
| wrdi_i | input | 1 | Write-disable command completed |
| op_full_i | input | 1 | Whole opcode received this cycle |
| op_cls_i | input | 4 | Class of the received opcode |
| done_i | input | 1 | Active command completed |
| abort_i | input | 1 | Active command aborted (chip select raised early or internal abort) |
| hold_abort_i | input | 1 | Hold condition aborted the operation |
| fail_i | input | 1 | At least one byte failed, valid with done_i |
| wp_i | input | 1 | Write-protect pin level |
| sect_prot_i | input | NSECT | Per-sector protect bits |
| grant_o | output | 1 | Modifying command accepted (one-cycle pulse) |
| refuse_o | output | 1 | Modifying command refused (one-cycle pulse) |
| status_o | output | 8 | Status byte |

## Verification
Every result is registered exactly once. A strobe or level driven before clock edge k shows up in `status_o`, `grant_o` and `refuse_o` right after edge k, and grant and refuse drop again after edge k+1. The bench drives inputs on the falling edge, lets one rising edge pass and samples on the next falling edge. Each check therefore sits one edge after its stimulus. The pulse checks also look one cycle later to confirm that the pulse lasts only one cycle.

// File: rtl/fws_pkg.sv
package fws_pkg;
  localparam int CLS_W  = 4;
  localparam int STAT_W = 8;

  localparam logic [CLS_W-1:0] CLS_PROG   = 4'd1;
  localparam logic [CLS_W-1:0] CLS_BERASE = 4'd2;
  localparam logic [CLS_W-1:0] CLS_CERASE = 4'd3;
  localparam logic [CLS_W-1:0] CLS_PROT   = 4'd4;
  localparam logic [CLS_W-1:0] CLS_UNPROT = 4'd5;
  localparam logic [CLS_W-1:0] CLS_LOCK   = 4'd6;
  localparam logic [CLS_W-1:0] CLS_FREEZE = 4'd7;
  localparam logic [CLS_W-1:0] CLS_OTP    = 4'd8;
  localparam logic [CLS_W-1:0] CLS_WRSR   = 4'd9;

  typedef enum logic [1:0] {
    PS_NONE = 2'b00,
    PS_SOME = 2'b01,
    PS_ALL  = 2'b11
  } prot_sum_e;

  localparam int SB_BUSY = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_PROT = 2;
  localparam int SB_WP   = 4;
  localparam int SB_ERR  = 5;

  function automatic logic is_modify(input logic [CLS_W-1:0] c);
    return (c >= CLS_PROG) && (c <= CLS_WRSR);
  endfunction

  function automatic logic is_erase_prog(input logic [CLS_W-1:0] c);
    return (c == CLS_PROG) || (c == CLS_BERASE) || (c == CLS_CERASE) || (c == CLS_OTP);
  endfunction
endpackage

// File: rtl/fws_rst_sync.sv
module fws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fws_cmd_track.sv
module fws_cmd_track
  import fws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_i,
  input  logic             op_full_i,
  input  logic [CLS_W-1:0] op_cls_i,
  input  logic             done_i,
  input  logic             abort_i,
  input  logic             hold_abort_i,
  input  logic             wel_i,
  output logic             busy_nx_o,
  output logic             grant_o,
  output logic             refuse_o,
  output logic             mod_end_o,
  output logic             ep_done_o
);
  logic             act_q, act_d;
  logic [CLS_W-1:0] cls_q, cls_d;
  logic             cls_en;
  logic             grant_q, grant_d, refuse_q, refuse_d;
  logic             new_mod, end_evt;

  always_comb begin
    new_mod   = op_full_i & is_modify(op_cls_i) & ~act_q;
    end_evt   = act_q & (done_i | abort_i | hold_abort_i);
    mod_end_o = act_q & (done_i | abort_i);
    ep_done_o = act_q & done_i & is_erase_prog(cls_q);

    act_d  = act_q;
    cls_d  = cls_q;
    cls_en = 1'b0;
    if (por_i) begin
      act_d = 1'b0;
    end else if (end_evt) begin
      act_d = 1'b0;
    end else if (new_mod && wel_i) begin
      act_d  = 1'b1;
      cls_d  = op_cls_i;
      cls_en = 1'b1;
    end

    grant_d  = ~por_i & new_mod & wel_i;
    refuse_d = ~por_i & new_mod & ~wel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      grant_q  <= 1'b0;
      refuse_q <= 1'b0;
    end else begin
      act_q    <= act_d;
      grant_q  <= grant_d;
      refuse_q <= refuse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cls_q <= '0;
    else if (cls_en) cls_q <= cls_d;
  end

  assign busy_nx_o = act_d;
  assign grant_o   = grant_q;
  assign refuse_o  = refuse_q;
endmodule

// File: rtl/fws_wel.sv
module fws_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic mod_end_i,
  input  logic hold_abort_i,
  output logic wel_o,
  output logic wel_nx_o
);
  logic wel_q, wel_d, wel_en, clr;

  always_comb begin
    clr    = por_i | wrdi_i | mod_end_i | hold_abort_i;
    wel_en = clr | wren_i;
    wel_d  = clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel_q <= 1'b0;
    else if (wel_en) wel_q <= wel_d;
  end

  assign wel_o    = wel_q;
  assign wel_nx_o = wel_en ? wel_d : wel_q;
endmodule

// File: rtl/fws_err.sv
module fws_err (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic ep_done_i,
  input  logic fail_i,
  output logic err_nx_o
);
  logic err_q, err_d, err_en;

  always_comb begin
    err_en = por_i | ep_done_i;
    err_d  = por_i ? 1'b0 : fail_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign err_nx_o = err_en ? err_d : err_q;
endmodule

// File: rtl/fws_prot_sum.sv
module fws_prot_sum
  import fws_pkg::*;
#(
  parameter int NSECT = 16
) (
  input  logic [NSECT-1:0] sect_prot_i,
  output logic [1:0]       sum_o
);
  logic any_set, all_set;
  prot_sum_e sum;

  always_comb begin
    any_set = |sect_prot_i;
    all_set = &sect_prot_i;
    if (all_set)      sum = PS_ALL;
    else if (any_set) sum = PS_SOME;
    else              sum = PS_NONE;
  end

  assign sum_o = sum;
endmodule

// File: rtl/flash_wel_status.sv
module flash_wel_status
  import fws_pkg::*;
#(
  parameter int NSECT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              op_full_i,
  input  logic [CLS_W-1:0]  op_cls_i,
  input  logic              done_i,
  input  logic              abort_i,
  input  logic              hold_abort_i,
  input  logic              fail_i,
  input  logic              wp_i,
  input  logic [NSECT-1:0]  sect_prot_i,
  output logic              grant_o,
  output logic              refuse_o,
  output logic [STAT_W-1:0] status_o
);
  logic rst_n_sync;
  logic wel, wel_nx, busy_nx, err_nx, mod_end, ep_done;
  logic [1:0] prot_sum;
  logic [STAT_W-1:0] status_d, status_q;

  fws_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  fws_cmd_track u_trk (
    .clk(clk), .rst_n(rst_n_sync), .por_i(por_i),
    .op_full_i(op_full_i), .op_cls_i(op_cls_i),
    .done_i(done_i), .abort_i(abort_i), .hold_abort_i(hold_abort_i),
    .wel_i(wel), .busy_nx_o(busy_nx), .grant_o(grant_o), .refuse_o(refuse_o),
    .mod_end_o(mod_end), .ep_done_o(ep_done)
  );

  fws_wel u_wel (
    .clk(clk), .rst_n(rst_n_sync), .por_i(por_i), .wren_i(wren_i),
    .wrdi_i(wrdi_i), .mod_end_i(mod_end), .hold_abort_i(hold_abort_i),
    .wel_o(wel), .wel_nx_o(wel_nx)
  );

  fws_err u_err (
    .clk(clk), .rst_n(rst_n_sync), .por_i(por_i),
    .ep_done_i(ep_done), .fail_i(fail_i), .err_nx_o(err_nx)
  );

  fws_prot_sum #(.NSECT(NSECT)) u_prot (
    .sect_prot_i(sect_prot_i), .sum_o(prot_sum)
  );

  always_comb begin
    status_d                   = '0;
    status_d[SB_BUSY]          = busy_nx;
    status_d[SB_WEL]           = wel_nx;
    status_d[SB_PROT+1:SB_PROT] = prot_sum;
    status_d[SB_WP]            = wp_i;
    status_d[SB_ERR]           = err_nx;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) status_q <= '0;
    else             status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/fws_checker.sv
module fws_checker #(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              por_i,
  input logic              wren_i,
  input logic              wrdi_i,
  input logic              done_i,
  input logic              hold_abort_i,
  input logic              wp_i,
  input logic              grant_o,
  input logic              refuse_o,
  input logic [STAT_W-1:0] status_o
);
  // R1
  por_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    por_i |=> (status_o[1] == 1'b0) && (status_o[5] == 1'b0) && (status_o[0] == 1'b0));
  // R2
  grant_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    grant_o |-> $past(status_o[1]));
  // R2
  refuse_no_wel_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    refuse_o |-> !$past(status_o[1]) && !status_o[0]);
  // R2
  grant_refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(grant_o && refuse_o));
  // R3
  wrdi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    wrdi_i |=> !status_o[1]);
  // R3
  wren_sets_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    wren_i && !wrdi_i && !por_i && !hold_abort_i && !status_o[0] |=> status_o[1]);
  // R5
  hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    hold_abort_i |=> !status_o[1] && !status_o[0]);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !done_i && !por_i |=> $stable(status_o[5]));
  // R9
  prot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    status_o[3:2] != 2'b10);
  // R10
  wp_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    1'b1 |=> status_o[4] == $past(wp_i));
  // R11
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    status_o[7:6] == 2'b00);
endmodule

bind flash_wel_status fws_checker #(.STAT_W(8)) u_chk (.*);

// File: tb/flash_wel_status_bench.sv
module flash_wel_status_bench;
  localparam int NSECT = 16;

  logic clk = 1'b0;
  logic rst_n, por_i, wren_i, wrdi_i, op_full_i, done_i, abort_i, hold_abort_i, fail_i, wp_i;
  logic [3:0] op_cls_i;
  logic [NSECT-1:0] sect_prot_i;
  logic grant_o, refuse_o;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  logic m_wel, m_err, m_busy;

  always #2.5 clk = ~clk;

  flash_wel_status #(.NSECT(NSECT)) u_flash_wel_status (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .wren_i(wren_i), .wrdi_i(wrdi_i),
    .op_full_i(op_full_i), .op_cls_i(op_cls_i), .done_i(done_i), .abort_i(abort_i),
    .hold_abort_i(hold_abort_i), .fail_i(fail_i), .wp_i(wp_i), .sect_prot_i(sect_prot_i),
    .grant_o(grant_o), .refuse_o(refuse_o), .status_o(status_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_prot();
    if (&sect_prot_i) return 2'b11;
    if (|sect_prot_i) return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk_status(input string req);
    chk(req, {24'd0, status_o}, {24'd0, 2'b00, m_err, wp_i, exp_prot(), m_wel, m_busy});
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_wren();
    wren_i = 1'b1; cyc(); wren_i = 1'b0; m_wel = 1'b1;
  endtask

  task automatic do_op(input logic [3:0] cls, input logic exp_grant, input logic exp_refuse, input string req);
    op_full_i = 1'b1; op_cls_i = cls; cyc(); op_full_i = 1'b0;
    chk({req, " grant"}, {31'd0, grant_o}, {31'd0, exp_grant});
    chk({req, " refuse"}, {31'd0, refuse_o}, {31'd0, exp_refuse});
    if (exp_grant) m_busy = 1'b1;
    chk_status({req, " status after opcode"});
    cyc();
    chk({req, " pulse width"}, {30'd0, grant_o, refuse_o}, 32'd0);
  endtask

  task automatic do_done(input logic f);
    done_i = 1'b1; fail_i = f; cyc(); done_i = 1'b0; fail_i = 1'b0;
  endtask

  task automatic do_abort();
    abort_i = 1'b1; cyc(); abort_i = 1'b0;
  endtask

  task automatic t_reset();
    chk_status("R1 reset state");
    chk("R1 no pulses", {30'd0, grant_o, refuse_o}, 32'd0);
  endtask

  task automatic t_refuse();
    do_op(4'd1, 1'b0, 1'b1, "R2 program refused");
    do_op(4'd9, 1'b0, 1'b1, "R2 write status refused");
  endtask

  task automatic t_program_fail();
    do_wren(); chk_status("R3 latch set");
    do_op(4'd1, 1'b1, 1'b0, "R2 program granted");
    do_done(1'b1); m_wel = 0; m_busy = 0; m_err = 1;
    chk_status("R4 R7 program done with failure");
  endtask

  task automatic t_abort_keeps_err();
    do_wren();
    do_op(4'd2, 1'b1, 1'b0, "R2 block erase granted");
    do_abort(); m_wel = 0; m_busy = 0;
    chk_status("R4 R8 erase abort clears latch keeps error");
    do_op(4'd3, 1'b0, 1'b1, "R8 refused chip erase");
    do_done(1'b0);
    chk_status("R8 refused erase leaves error");
    do_wren();
    do_op(4'd3, 1'b1, 1'b0, "R2 chip erase granted");
    do_done(1'b0); m_wel = 0; m_busy = 0; m_err = 0;
    chk_status("R7 chip erase success clears error");
  endtask

  task automatic t_no_clear();
    do_wren();
    do_abort();
    chk_status("R6 abort before full opcode keeps latch");
    do_op(4'd12, 1'b0, 1'b0, "R6 unrecognized opcode");
    do_abort();
    chk_status("R6 abort after unrecognized opcode keeps latch");
    do_op(4'd0, 1'b0, 1'b0, "R6 non-modifying opcode");
    do_done(1'b1);
    chk_status("R6 R7 non-modifying done keeps latch and error");
  endtask

  task automatic t_wrdi();
    wrdi_i = 1'b1; cyc(); wrdi_i = 1'b0; m_wel = 0;
    chk_status("R3 write disable clears latch");
  endtask

  task automatic t_hold();
    do_wren();
    do_op(4'd4, 1'b1, 1'b0, "R2 protect granted");
    hold_abort_i = 1'b1; cyc(); hold_abort_i = 1'b0; m_wel = 0; m_busy = 0;
    chk_status("R5 hold abort clears latch and busy");
    do_wren();
    hold_abort_i = 1'b1; cyc(); hold_abort_i = 1'b0; m_wel = 0;
    chk_status("R5 hold abort while idle clears latch");
  endtask

  task automatic t_non_ep();
    do_wren();
    do_op(4'd9, 1'b1, 1'b0, "R2 write status granted");
    do_done(1'b1); m_wel = 0; m_busy = 0;
    chk_status("R4 R7 write status done clears latch, not error");
    do_wren();
    do_op(4'd8, 1'b1, 1'b0, "R2 OTP program granted");
    do_done(1'b1); m_wel = 0; m_busy = 0; m_err = 1;
    chk_status("R7 OTP program failure sets error");
  endtask

  task automatic t_conflict();
    wren_i = 1'b1; wrdi_i = 1'b1; cyc(); wren_i = 1'b0; wrdi_i = 1'b0;
    chk_status("R3 simultaneous set and clear");
  endtask

  task automatic t_prot_wp();
    sect_prot_i = 16'h0010; cyc(); chk("R9 some protected", {30'd0, status_o[3:2]}, 32'd1);
    sect_prot_i = 16'hFFFF; cyc(); chk("R9 all protected", {30'd0, status_o[3:2]}, 32'd3);
    sect_prot_i = 16'h7FFF; cyc(); chk("R9 one open", {30'd0, status_o[3:2]}, 32'd1);
    sect_prot_i = 16'h0000; cyc(); chk("R9 none protected", {30'd0, status_o[3:2]}, 32'd0);
    wp_i = 1'b1; cyc(); chk("R10 wp high", {31'd0, status_o[4]}, 32'd1);
    chk("R11 upper bits zero", {30'd0, status_o[7:6]}, 32'd0);
    wp_i = 1'b0; cyc(); chk("R10 wp low", {31'd0, status_o[4]}, 32'd0);
  endtask

  task automatic t_por();
    do_wren();
    do_op(4'd1, 1'b1, 1'b0, "R2 program granted before por");
    por_i = 1'b1; cyc(); por_i = 1'b0; m_wel = 0; m_busy = 0; m_err = 0;
    chk_status("R1 por clears latch busy error");
  endtask

  initial begin
    rst_n = 1'b0; por_i = 0; wren_i = 0; wrdi_i = 0; op_full_i = 0; op_cls_i = '0;
    done_i = 0; abort_i = 0; hold_abort_i = 0; fail_i = 0; wp_i = 0; sect_prot_i = '0;
    m_wel = 0; m_err = 0; m_busy = 0;
    repeat (3) cyc();
    t_reset();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_refuse();
    t_program_fail();
    t_abort_keeps_err();
    t_no_clear();
    t_wrdi();
    t_hold();
    t_non_ep();
    t_conflict();
    t_prot_wp();
    t_por();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule